// File: doc/BRIEF.md
# Wide-Bus Information-Unit CRC32 Engine

This block computes and verifies the 32-bit CRC that protects information units on a 16-bit double-transition data bus. Bus words enter one at a time. Two consecutive words form one 32-bit CRC word. The bits of every byte are mirrored before the byte enters an MSB-first division by the generator polynomial. The remainder register is loaded with all ones at the start of every unit and again after every CRC pair.

In generate mode, the engine closes a segment in one of two cases: the unit ends, or a programmed byte interval has been reached. It then holds off upstream and emits two CRC bus words. These carry the complemented remainder with the bytes in wide-bus lane order.

In check mode, the engine does not emit CRC words. It treats the two upstream words that follow each segment as the received CRC and passes them through. It folds them into the remainder and compares the result against the fixed residue. A mismatch produces a one-cycle error pulse.

Top module: `iu_crc_engine`

## Requirements
- R1: During and directly after reset, out_valid, out_crc and crc_err are 0 and in_ready is 1.
- R2: Every data word accepted while in_valid and in_ready are both high appears on out_data, with out_valid high and out_crc low, in the following cycle.
- R3: Byte 0 of a 32-bit CRC word is in_data[7:0] of the first of two transfers, byte 1 is in_data[15:8] of that transfer, and bytes 2 and 3 are the low and high lanes of the second transfer. Each byte is bit-reversed, and byte 0 enters the division first, with polynomial 104C11DB7h and an all-ones preset.
- R4: In generate mode, CRC byte k is the bit-reversed ones-complement of remainder bits [31-8k:24-8k]. The first CRC bus word is {byte1, byte0} and the second is {byte3, byte2}, both flagged by out_crc high. They follow the last data word of the segment directly.
- R5: With interval 0, a unit of 32 zero bytes yields CRC words 55ADh then 190Ah. A unit of 32 FFh bytes yields AB0Bh then FF6Ch. The bytes 00h through 1Fh in order yield 7E8Ah then 9126h.
- R6: With a nonzero interval (a multiple of 4 bytes), a CRC pair closes every run of that many data bytes, and the remainder is preset to all ones afterwards.
- R7: With interval 0, the only CRC pair of a unit follows the data word carrying in_last. Units are a multiple of 4 bytes, and in_last accompanies the second word of a pair.
- R8: When the end of a unit falls exactly on an interval boundary, exactly one CRC pair is produced there.
- R9: In generate mode, in_ready is low for exactly the two cycles in which a CRC pair is being emitted.
- R10: In check mode, in_ready stays high. The two words after each segment are consumed as CRC and appear on out_data one cycle later, with out_crc high.
- R11: In check mode, crc_err pulses for one cycle, alongside the second CRC word on the output, exactly when the remainder after that word differs from C704DD7Bh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_check | input | 1 | 0 = generate CRC words, 1 = check received CRC words |
| interval | input | 16 | Bytes per CRC segment, 0 = one CRC per unit |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Engine accepts a word this cycle |
| in_data | input | 16 | Upstream bus word |
| in_last | input | 1 | Last data word of the unit |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output bus word |
| out_crc | output | 1 | Output word is a CRC word |
| crc_err | output | 1 | One-cycle CRC mismatch pulse |

## Verification
Two closing conditions can fall on the same data word: the interval counter reaching its limit, and the upstream end-of-unit mark. The sweep provokes this by running unit lengths that are exact multiples of the interval, next to lengths that leave a short final segment. In each case it compares the whole captured output stream against a bench-computed stream that holds one CRC pair per boundary. Any duplicated or missing pair shows up as a length or word mismatch. The stall count and the error pulse count are judged per unit in the same run.

// File: rtl/iu_crc_pkg.sv
package iu_crc_pkg;
    localparam int BUS_W  = 16;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [1:0] {
        SEQ_DATA,
        SEQ_CRC_A,
        SEQ_CRC_B
    } seq_state_t;

    typedef struct packed {
        logic             valid;
        logic             is_crc;
        logic [BUS_W-1:0] data;
    } out_beat_t;

    function automatic logic [7:0] mirror8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] divide_msb_first(
        input logic [WORD_W-1:0] rem,
        input logic [WORD_W-1:0] word
    );
        logic [WORD_W-1:0] r;
        logic fb;
        r = rem;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[WORD_W-1] ^ word[i];
            r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction
endpackage

// File: rtl/iu_crc_word_update.sv
module iu_crc_word_update
    import iu_crc_pkg::*;
(
    input  logic [WORD_W-1:0] rem_in,
    input  logic [BUS_W-1:0]  first_beat,
    input  logic [BUS_W-1:0]  second_beat,
    output logic [WORD_W-1:0] rem_out
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] lanes;
    logic [WORD_W-1:0] mirrored;

    assign lanes = {second_beat, first_beat};

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign mirrored[WORD_W-1-8*k -: 8] = mirror8(lanes[8*k +: 8]);
    end

    assign rem_out = divide_msb_first(rem_in, mirrored);
endmodule

// File: rtl/iu_crc_lane_pack.sv
module iu_crc_lane_pack
    import iu_crc_pkg::*;
(
    input  logic [WORD_W-1:0] rem,
    output logic [BUS_W-1:0]  beat_a,
    output logic [BUS_W-1:0]  beat_b
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] tx_bytes;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign tx_bytes[8*k +: 8] = mirror8(~rem[WORD_W-1-8*k -: 8]);
    end

    assign beat_a = tx_bytes[BUS_W-1:0];
    assign beat_b = tx_bytes[WORD_W-1:BUS_W];
endmodule

// File: rtl/iu_crc_engine.sv
module iu_crc_engine
    import iu_crc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_check,
    input  logic [CNT_W-1:0] interval,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_data,
    input  logic             in_last,
    output logic             out_valid,
    output logic [15:0]      out_data,
    output logic             out_crc,
    output logic             crc_err
);
    localparam logic [CNT_W-1:0] BYTES_PER_WORD = CNT_W'(WORD_W / 8);

    seq_state_t        state_q;
    logic              half_q;
    logic [BUS_W-1:0]  hold_q;
    logic [WORD_W-1:0] rem_q;
    logic [CNT_W-1:0]  count_q;
    out_beat_t         beat_q;
    logic              err_q;

    logic [WORD_W-1:0] rem_upd;
    logic [BUS_W-1:0]  crc_beat_a;
    logic [BUS_W-1:0]  crc_beat_b;
    logic [CNT_W-1:0]  count_next;
    logic              interval_hit;
    logic              accept;

    iu_crc_word_update u_update (
        .rem_in      (rem_q),
        .first_beat  (hold_q),
        .second_beat (in_data),
        .rem_out     (rem_upd)
    );

    iu_crc_lane_pack u_pack (
        .rem    (rem_q),
        .beat_a (crc_beat_a),
        .beat_b (crc_beat_b)
    );

    assign count_next   = count_q + BYTES_PER_WORD;
    assign interval_hit = (interval != '0) && (count_next == interval);
    assign in_ready     = (state_q == SEQ_DATA) || mode_check;
    assign accept       = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_DATA;
            half_q  <= 1'b0;
            hold_q  <= '0;
            rem_q   <= CRC_PRESET;
            count_q <= '0;
            beat_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            beat_q <= '0;
            err_q  <= 1'b0;
            case (state_q)
                SEQ_DATA: begin
                    if (accept) begin
                        beat_q <= '{valid: 1'b1, is_crc: 1'b0, data: in_data};
                        if (!half_q) begin
                            hold_q <= in_data;
                            half_q <= 1'b1;
                        end else begin
                            half_q  <= 1'b0;
                            rem_q   <= rem_upd;
                            count_q <= count_next;
                            if (in_last || interval_hit) state_q <= SEQ_CRC_A;
                        end
                    end
                end
                SEQ_CRC_A: begin
                    if (mode_check) begin
                        if (accept) begin
                            beat_q  <= '{valid: 1'b1, is_crc: 1'b1, data: in_data};
                            hold_q  <= in_data;
                            state_q <= SEQ_CRC_B;
                        end
                    end else begin
                        beat_q  <= '{valid: 1'b1, is_crc: 1'b1, data: crc_beat_a};
                        state_q <= SEQ_CRC_B;
                    end
                end
                SEQ_CRC_B: begin
                    if (mode_check) begin
                        if (accept) begin
                            beat_q  <= '{valid: 1'b1, is_crc: 1'b1, data: in_data};
                            err_q   <= (rem_upd != CRC_RESIDUE);
                            rem_q   <= CRC_PRESET;
                            count_q <= '0;
                            state_q <= SEQ_DATA;
                        end
                    end else begin
                        beat_q  <= '{valid: 1'b1, is_crc: 1'b1, data: crc_beat_b};
                        rem_q   <= CRC_PRESET;
                        count_q <= '0;
                        state_q <= SEQ_DATA;
                    end
                end
                default: state_q <= SEQ_DATA;
            endcase
        end
    end

    assign out_valid = beat_q.valid;
    assign out_crc   = beat_q.is_crc;
    assign out_data  = beat_q.data;
    assign crc_err   = err_q;
endmodule

// File: rtl/iu_crc_engine_chk.sv
module iu_crc_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_check,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_data,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        out_crc,
    input logic        crc_err
);
    assert_err_on_crc_beat_R11: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> (out_valid && out_crc && mode_check));

    assert_err_single_R11: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err);

    assert_data_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_crc) |-> ($past(in_valid && in_ready) && out_data == $past(in_data)));

    assert_check_passthru_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_check && $past(mode_check) && out_valid)
            |-> ($past(in_valid && in_ready) && out_data == $past(in_data)));

    assert_gen_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_check && $rose(out_crc)) |=> (out_crc && out_valid));

    assert_gen_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (!mode_check && $past(!mode_check) && out_valid && out_crc) |-> $past(!in_ready));
endmodule

bind iu_crc_engine iu_crc_engine_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_check (mode_check),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_crc    (out_crc),
    .crc_err    (crc_err)
);

// File: tb/iu_crc_engine_tb.sv
module iu_crc_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_check;
    logic [15:0] interval;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_data;
    logic        in_last;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_crc;
    logic        crc_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  msg   [0:255];
    logic [16:0] exp_w [0:511];
    logic [16:0] in_w  [0:511];
    logic [16:0] cap_w [0:511];
    int exp_n, in_n, cap_n, err_seen, stall_seen;
    bit mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iu_crc_engine dut_i (
        .clk(clk), .rst(rst), .mode_check(mode_check), .interval(interval),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data), .out_crc(out_crc), .crc_err(crc_err)
    );

    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (cap_n < 512) cap_w[cap_n] = {out_crc, out_data};
                cap_n++;
            end
            if (crc_err) err_seen++;
            if (!in_ready) stall_seen++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int start, input int len);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, msg[start+i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic push(input logic [15:0] d, input logic last);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_unit(input bit chk, input int len, input int ival,
                            input int pat, input int bad_seg);
        int pos, seg, nseg, exp_err;
        logic [31:0] c;
        string tag;
        for (int i = 0; i < len; i++) begin
            case (pat)
                0: msg[i] = 8'h00;
                1: msg[i] = 8'hFF;
                2: msg[i] = 8'(i);
                default: msg[i] = 8'((i * 37 + 11) & 255);
            endcase
        end
        exp_n = 0; in_n = 0; pos = 0; nseg = 0; exp_err = 0;
        while (pos < len) begin
            seg = (ival == 0 || len - pos < ival) ? len - pos : ival;
            for (int i = 0; i < seg; i += 2) begin
                logic [15:0] w;
                w = {msg[pos+i+1], msg[pos+i]};
                exp_w[exp_n] = {1'b0, w}; exp_n++;
                in_w[in_n] = {(pos + i + 2 == len), w}; in_n++;
            end
            c = ref_crc(pos, seg);
            if (chk && nseg == bad_seg) begin
                c = c ^ 32'h0000_0100;
                exp_err++;
            end
            exp_w[exp_n] = {1'b1, c[15:0]};  exp_n++;
            exp_w[exp_n] = {1'b1, c[31:16]}; exp_n++;
            if (chk) begin
                in_w[in_n] = {1'b0, c[15:0]};  in_n++;
                in_w[in_n] = {1'b0, c[31:16]}; in_n++;
            end
            pos += seg;
            nseg++;
        end
        mode_check = chk;
        interval   = 16'(ival);
        @(negedge clk);
        cap_n = 0; err_seen = 0; stall_seen = 0; mon_en = 1'b1;
        for (int i = 0; i < in_n; i++) push(in_w[i][15:0], in_w[i][16]);
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
        if (chk) tag = "R10 R11";
        else if (ival == 0) tag = "R3 R4 R7";
        else if (len % ival == 0) tag = "R4 R6 R8";
        else tag = "R4 R6";
        begin
            int first_bad;
            first_bad = -1;
            for (int i = 0; i < exp_n && i < cap_n; i++)
                if (first_bad < 0 && cap_w[i] !== exp_w[i]) first_bad = i;
            check(cap_n == exp_n, {tag, " R2 word count"}, cap_n, exp_n);
            if (first_bad >= 0)
                check(1'b0, {tag, " R2 stream word"}, int'(cap_w[first_bad]),
                      int'(exp_w[first_bad]));
            else
                check(1'b1, tag, 0, 0);
        end
        check(err_seen == exp_err, "R11 error pulses", err_seen, exp_err);
        check(stall_seen == (chk ? 0 : 2 * nseg), "R9 stall cycles", stall_seen,
              chk ? 0 : 2 * nseg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ivals [5] = '{0, 4, 8, 12, 20};
        rst = 1'b1; mode_check = 1'b0; interval = 16'd0;
        in_valid = 1'b0; in_data = 16'd0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_crc == 1'b0, "R1 outputs in reset", out_valid, 0);
        check(crc_err == 1'b0, "R1 crc_err in reset", crc_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
              {in_ready, out_valid}, 2);

        // R5 known vectors
        run_unit(1'b0, 32, 0, 0, -1);
        check(cap_w[16] == 17'h155AD && cap_w[17] == 17'h1190A, "R5 zeros",
              int'({cap_w[16][15:0], cap_w[17][15:0]}), 32'h55AD190A);
        run_unit(1'b0, 32, 0, 1, -1);
        check(cap_w[16] == 17'h1AB0B && cap_w[17] == 17'h1FF6C, "R5 ones",
              int'({cap_w[16][15:0], cap_w[17][15:0]}), 32'hAB0BFF6C);
        run_unit(1'b0, 32, 0, 2, -1);
        check(cap_w[16] == 17'h17E8A && cap_w[17] == 17'h19126, "R5 ramp",
              int'({cap_w[16][15:0], cap_w[17][15:0]}), 32'h7E8A9126);

        // sweep over modes, lengths, intervals, patterns
        for (int m = 0; m < 2; m++)
            for (int len = 4; len <= 48; len += 4)
                for (int iv = 0; iv < 5; iv++)
                    for (int p = 0; p < 4; p++)
                        run_unit(m[0], len, ivals[iv], p, -1);

        // R11 corrupted CRC in various segments
        run_unit(1'b1, 24, 8, 3, 0);
        run_unit(1'b1, 24, 8, 3, 1);
        run_unit(1'b1, 24, 8, 3, 2);
        run_unit(1'b1, 20, 8, 2, 2);
        run_unit(1'b1, 32, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule